// File: doc/BRIEF.md
# Framebuffer Rectangle Mover

This block copies a rectangle of 16-bit pixels between a 32-bit word port and a framebuffer organised as rows of halfwords. The rectangle is given by an origin column, an origin row, a width and a height. The framebuffer itself sits outside the block and is reached through a single-cycle synchronous halfword port. A read on that port returns its data one cycle after the request.

Each port word holds two pixels, and the pixel in bits 15:0 goes first. In the write direction the block accepts a word with a valid/ready handshake and stores its two halves at two consecutive pixel positions. In the read direction it fetches two halfwords, packs them into a word and offers the word with a valid/ready handshake. Positions step along a row, then jump to the next row one full row stride further on. Addresses wrap at the end of the framebuffer. When the last row is complete, busy drops and done pulses. An abort input stops a transfer in either direction at once.

Top module: `fbx_rect_mover`

## Requirements
- R1: Reset behaviour. After reset, busy, done, wr_ready, rd_valid, fb_we and fb_re are all low.
- R2: Starting a transfer. A start is taken only while the block is idle and only when width and height are both nonzero. When it is taken, busy goes high on the next cycle. Any other start has no effect, including one that arrives while a transfer runs. The dir input selects the direction: 0 writes the framebuffer, 1 reads it.
- R3: Pixel addressing. Number the pixels k = 0, 1, 2, … in transfer order. Pixel k sits at halfword address (org_y·S + org_x + (k div width)·S + (k mod width)), where S = 2^XW is the row stride. With the default XW = 10, S is 1024.
- R4: Address wrap. Every address is taken modulo the framebuffer size 2^(XW+YW). With the defaults that is 512K halfwords, so a rectangle that runs past the last halfword continues from address 0.
- R5: Write order. Each accepted word writes bits 15:0 to pixel 2j and bits 31:16 to pixel 2j+1, the low half first. wr_ready stays low during the cycle in which the high half is being written.
- R6: Odd pixel count on writes. If the last pixel comes from the low half of a word, the high half of that word is not written anywhere.
- R7: Read packing. Read word j carries pixel 2j in bits 15:0 and pixel 2j+1 in bits 31:16. The upper half is always fetched. When the pixel count is odd, it comes from the position that follows the last pixel, which is column 0 of row `height`.
- R8: Read hold. While rd_valid is high and rd_ready is low, rd_valid stays high and rd_data stays unchanged.
- R9: Completion. The transfer ends on the cycle that moves the last pixel; for a read, that is the handshake of the last word. On the following cycle done is high for exactly one cycle and busy is low.
- R10: Abort. A high abort stops the transfer in either direction. From the next cycle busy, done, wr_ready and rd_valid are low. No framebuffer write happens in the abort cycle or afterwards.
- R11: Port exclusivity. fb_we and fb_re are never high together. wr_ready is high only during a write transfer and rd_valid only during a read transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort | input | 1 | Stops any transfer in progress |
| start | input | 1 | Begins a transfer with the fields below |
| dir | input | 1 | 0 = port to framebuffer, 1 = framebuffer to port |
| org_x | input | XW | Origin column |
| org_y | input | YW | Origin row |
| width | input | XW+1 | Pixels per row, 1 to 2^XW |
| height | input | YW+1 | Rows, 1 to 2^YW |
| wr_data | input | 2*HW | Word carrying two pixels, low half first |
| wr_valid | input | 1 | wr_data is offered |
| wr_ready | output | 1 | Block takes wr_data this cycle |
| rd_data | output | 2*HW | Packed pixel pair |
| rd_valid | output | 1 | rd_data is offered |
| rd_ready | input | 1 | Consumer takes rd_data this cycle |
| fb_addr | output | XW+YW | Framebuffer halfword address |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_wdata | output | HW | Framebuffer write data |
| fb_re | output | 1 | Framebuffer read strobe, data returns next cycle |
| fb_rdata | input | HW | Framebuffer read data |
| busy | output | 1 | A transfer is active |
| done | output | 1 | One-cycle pulse after the last pixel |

## Verification
The bench builds the block with XW = 4 and YW = 3. That gives a framebuffer of 8 rows of 16 halfwords, 128 halfwords in all, small enough to model in full and compare completely after every transfer. At this size the bench can reach:
- a rectangle as wide as the stride;
- a full-frame read;
- rows that spill past the stride into the next row;
- rectangles that wrap past the last halfword back to address 0.

All of these are reached with short transfers, so the odd-count cases and the read that fetches beyond the last pixel get exercised alongside the ordinary ones.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } xfer_dir_e;

  typedef enum logic [1:0] {
    RD_LO,
    RD_HI,
    RD_CAP,
    RD_OUT
  } rd_phase_e;
endpackage

// File: rtl/fbx_addr_gen.sv
module fbx_addr_gen #(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [XW-1:0]     org_x,
  input  logic [YW-1:0]     org_y,
  input  logic [XW:0]       width,
  input  logic [YW:0]       height,
  output logic [XW+YW-1:0]  addr,
  output logic              row_end,
  output logic              last_px
);
  localparam int AW     = XW + YW;
  localparam int STRIDE = 1 << XW;

  // y*STRIDE + x is a plain concatenation because the stride is a power of two
  function automatic logic [AW-1:0] origin_of(input logic [XW-1:0] x, input logic [YW-1:0] y);
    return {y, x};
  endfunction

  // next row base, truncation to AW bits gives the framebuffer wrap
  function automatic logic [AW-1:0] next_row(input logic [AW-1:0] b);
    return b + AW'(STRIDE);
  endfunction

  logic [AW-1:0] row_base;
  logic [XW:0]   col;
  logic [YW:0]   row;
  logic [XW:0]   w_q;
  logic [YW:0]   h_q;

  assign addr    = row_base + AW'(col);
  assign row_end = (col + (XW+1)'(1)) == w_q;
  assign last_px = row_end && ((row + (YW+1)'(1)) == h_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_base <= '0;
      col      <= '0;
      row      <= '0;
      w_q      <= '0;
      h_q      <= '0;
    end else if (load) begin
      row_base <= origin_of(org_x, org_y);
      col      <= '0;
      row      <= '0;
      w_q      <= width;
      h_q      <= height;
    end else if (step) begin
      if (row_end) begin
        col      <= '0;
        row_base <= next_row(row_base);
        row      <= row + (YW+1)'(1);
      end else begin
        col <= col + (XW+1)'(1);
      end
    end
  end
endmodule

// File: rtl/fbx_wr_path.sv
module fbx_wr_path #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          active,
  input  logic [2*HW-1:0] wr_data,
  input  logic          wr_valid,
  input  logic          last_px,
  output logic          wr_ready,
  output logic          fire,
  output logic          hi_cycle,
  output logic          fb_we,
  output logic [HW-1:0] fb_wdata
);
  logic          hi_pend;
  logic [HW-1:0] hi_buf;

  assign wr_ready = active && !hi_pend;
  assign fire     = wr_valid && wr_ready;
  assign hi_cycle = active && hi_pend;
  assign fb_we    = fire || hi_cycle;
  assign fb_wdata = fire ? wr_data[HW-1:0] : hi_buf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_pend <= 1'b0;
      hi_buf  <= '0;
    end else if (clr) begin
      hi_pend <= 1'b0;
    end else if (fire) begin
      hi_buf  <= wr_data[2*HW-1:HW];
      hi_pend <= !last_px;   // a word ending on its low half drops the upper half
    end else if (hi_cycle) begin
      hi_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/fbx_rd_path.sv
module fbx_rd_path
  import fbx_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            active,
  input  logic            last_px,
  input  logic [HW-1:0]   fb_rdata,
  input  logic            rd_ready,
  output logic            fb_re,
  output logic            step,
  output logic            rd_valid,
  output logic [2*HW-1:0] rd_data,
  output logic            word_done,
  output logic            fin
);
  rd_phase_e       ph;
  logic            fin_q;
  logic [HW-1:0]   lo_q;
  logic [2*HW-1:0] out_q;

  assign fb_re     = active && (ph == RD_LO || ph == RD_HI);
  // upper half is always fetched, but the position stops after the last pixel
  assign step      = active && (ph == RD_LO || (ph == RD_HI && !fin_q));
  assign rd_valid  = active && (ph == RD_OUT);
  assign rd_data   = out_q;
  assign word_done = rd_valid && rd_ready;
  assign fin       = fin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= RD_LO;
      fin_q <= 1'b0;
      lo_q  <= '0;
      out_q <= '0;
    end else if (clr) begin
      ph    <= RD_LO;
      fin_q <= 1'b0;
    end else if (active) begin
      case (ph)
        RD_LO: begin
          if (last_px) fin_q <= 1'b1;
          ph <= RD_HI;
        end
        RD_HI: begin
          lo_q <= fb_rdata;
          if (!fin_q && last_px) fin_q <= 1'b1;
          ph <= RD_CAP;
        end
        RD_CAP: begin
          out_q <= {fb_rdata, lo_q};
          ph    <= RD_OUT;
        end
        default: begin
          if (rd_ready) ph <= RD_LO;
        end
      endcase
    end
  end
endmodule

// File: rtl/fbx_rect_mover.sv
module fbx_rect_mover
  import fbx_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int HW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic              dir,
  input  logic [XW-1:0]     org_x,
  input  logic [YW-1:0]     org_y,
  input  logic [XW:0]       width,
  input  logic [YW:0]       height,
  input  logic [2*HW-1:0]   wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [2*HW-1:0]   rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [XW+YW-1:0]  fb_addr,
  output logic              fb_we,
  output logic [HW-1:0]     fb_wdata,
  output logic              fb_re,
  input  logic [HW-1:0]     fb_rdata,
  output logic              busy,
  output logic              done
);
  logic      busy_q;
  logic      done_q;
  xfer_dir_e dir_q;

  // named internal events, also seen by the bound checker
  logic start_ok;
  logic wr_active;
  logic rd_active;
  logic clr;
  logic step;
  logic last_px;
  logic row_end;
  logic finish;
  logic wr_fire;
  logic wr_hi;
  logic rd_step;
  logic rd_word_done;
  logic rd_fin;

  assign start_ok  = start && !busy_q && !abort && (|width) && (|height);
  assign wr_active = busy_q && (dir_q == DIR_WRITE) && !abort;
  assign rd_active = busy_q && (dir_q == DIR_READ) && !abort;
  assign clr       = abort || !busy_q;
  assign step      = wr_fire || wr_hi || rd_step;
  assign finish    = ((wr_fire || wr_hi) && last_px) || (rd_word_done && rd_fin);

  fbx_addr_gen #(.XW(XW), .YW(YW)) i_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_ok),
    .step    (step),
    .org_x   (org_x),
    .org_y   (org_y),
    .width   (width),
    .height  (height),
    .addr    (fb_addr),
    .row_end (row_end),
    .last_px (last_px)
  );

  fbx_wr_path #(.HW(HW)) i_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .active   (wr_active),
    .wr_data  (wr_data),
    .wr_valid (wr_valid),
    .last_px  (last_px),
    .wr_ready (wr_ready),
    .fire     (wr_fire),
    .hi_cycle (wr_hi),
    .fb_we    (fb_we),
    .fb_wdata (fb_wdata)
  );

  fbx_rd_path #(.HW(HW)) i_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .active    (rd_active),
    .last_px   (last_px),
    .fb_rdata  (fb_rdata),
    .rd_ready  (rd_ready),
    .fb_re     (fb_re),
    .step      (rd_step),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .word_done (rd_word_done),
    .fin       (rd_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dir_q  <= DIR_WRITE;
    end else begin
      done_q <= finish && !abort;
      if (abort)         busy_q <= 1'b0;
      else if (start_ok) begin
        busy_q <= 1'b1;
        dir_q  <= xfer_dir_e'(dir);
      end else if (finish) busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/fbx_rect_mover_chk.sv
module fbx_rect_mover_chk #(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int HW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            abort,
  input logic            start,
  input logic [XW:0]     width,
  input logic [YW:0]     height,
  input logic            busy,
  input logic            done,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [2*HW-1:0] rd_data,
  input logic            fb_we,
  input logic            fb_re,
  input logic            step,
  input logic            last_px,
  input logic            finish
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy && !done);

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && (width == '0 || height == '0) |=> !busy);

  assert_start_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !abort && width != '0 && height != '0 |=> busy);

  assert_step_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> busy);

  assert_hi_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !last_px && !abort |=> (fb_we && !wr_ready) || abort);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !abort |=> (rd_valid && $stable(rd_data)) || abort);

  assert_done_after_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    finish && !abort |=> done && !busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done || $past(abort));

  assert_abort_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && !done && !wr_ready && !rd_valid);

  assert_abort_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !fb_we);

  assert_port_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fb_we && fb_re));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fb_we && !fb_re && !wr_ready && !rd_valid);

  assert_dir_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ready && rd_valid));
endmodule

bind fbx_rect_mover fbx_rect_mover_chk #(.XW(XW), .YW(YW), .HW(HW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .abort    (abort),
  .start    (start),
  .width    (width),
  .height   (height),
  .busy     (busy),
  .done     (done),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .fb_we    (fb_we),
  .fb_re    (fb_re),
  .step     (step),
  .last_px  (last_px),
  .finish   (finish)
);

// File: tb/test_fbx_rect_mover.sv
module test_fbx_rect_mover;
  localparam int XW  = 4;
  localparam int YW  = 3;
  localparam int HW  = 16;
  localparam int S   = 1 << XW;
  localparam int FBN = 1 << (XW + YW);

  typedef struct packed {
    logic       d;
    logic [3:0] ox;
    logic [2:0] oy;
    logic [4:0] w;
    logic [3:0] h;
  } vec_t;

  // dir, origin x, origin y, width, height
  localparam vec_t VEC [8] = '{
    '{1'b0, 4'd2,  3'd1, 5'd4,  4'd3},
    '{1'b0, 4'd5,  3'd2, 5'd3,  4'd3},
    '{1'b0, 4'd10, 3'd6, 5'd9,  4'd4},
    '{1'b1, 4'd0,  3'd0, 5'd16, 4'd8},
    '{1'b1, 4'd3,  3'd4, 5'd5,  4'd3},
    '{1'b1, 4'd12, 3'd7, 5'd6,  4'd2},
    '{1'b0, 4'd0,  3'd0, 5'd1,  4'd1},
    '{1'b1, 4'd15, 3'd7, 5'd1,  4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abort = 1'b0;
  logic start = 1'b0;
  logic dir = 1'b0;
  logic [XW-1:0] org_x = '0;
  logic [YW-1:0] org_y = '0;
  logic [XW:0] width = '0;
  logic [YW:0] height = '0;
  logic [2*HW-1:0] wr_data = '0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [2*HW-1:0] rd_data;
  logic rd_valid;
  logic rd_ready = 1'b0;
  logic [XW+YW-1:0] fb_addr;
  logic fb_we;
  logic [HW-1:0] fb_wdata;
  logic fb_re;
  logic [HW-1:0] fb_rdata = '0;
  logic busy;
  logic done;

  logic [HW-1:0] mem [FBN];
  logic pre_we = 1'b0;
  int pre_addr = 0;
  logic [HW-1:0] pre_data = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (pre_we) mem[pre_addr[XW+YW-1:0]] <= pre_data;
    else if (fb_we) mem[fb_addr] <= fb_wdata;
    if (fb_re) fb_rdata <= mem[fb_addr];
  end

  fbx_rect_mover #(.XW(XW), .YW(YW), .HW(HW)) i_fbx_rect_mover (
    .clk(clk), .rst_n(rst_n), .abort(abort), .start(start), .dir(dir),
    .org_x(org_x), .org_y(org_y), .width(width), .height(height),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .fb_addr(fb_addr), .fb_we(fb_we), .fb_wdata(fb_wdata), .fb_re(fb_re),
    .fb_rdata(fb_rdata), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // reference position of pixel k, written independently of the design
  function automatic int ref_addr(int ox, int oy, int w, int k);
    return (oy * S + ox + (k / w) * S + (k % w)) % FBN;
  endfunction

  function automatic logic [HW-1:0] pix(int v, int k);
    return 16'((v + 1) * 4096 + k * 7 + 3);
  endfunction

  function automatic logic [HW-1:0] rpat(int a);
    return 16'((a * 37) ^ 23040);
  endfunction

  function automatic string vec_tag(int v);
    case (v)
      0: return "R5";
      1: return "R6";
      2: return "R4";
      3: return "R3";
      4: return "R7";
      5: return "R4";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic preload(input bit pattern);
    for (int a = 0; a < FBN; a++) begin
      @(negedge clk);
      pre_we = 1'b1;
      pre_addr = a;
      pre_data = pattern ? rpat(a) : 16'hDEAD;
    end
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic issue(input logic d, input int ox, input int oy, input int w, input int h);
    @(negedge clk);
    start = 1'b1;
    dir = d;
    org_x = XW'(ox);
    org_y = YW'(oy);
    width = (XW+1)'(w);
    height = (YW+1)'(h);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 64 && !seen; i++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic send_word(input logic [31:0] d);
    int n = 0;
    wr_data = d;
    wr_valid = 1'b1;
    while (!wr_ready && n < 50) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run_vec(input int v);
    int ox = int'(VEC[v].ox);
    int oy = int'(VEC[v].oy);
    int w = int'(VEC[v].w);
    int h = int'(VEC[v].h);
    int np = w * h;
    int nw = (np + 1) / 2;
    bit seen;
    string tag = vec_tag(v);
    logic [HW-1:0] ex [FBN];
    logic [31:0] hold;
    int n;
    int miss;
    int first;
    preload(VEC[v].d);
    issue(VEC[v].d, ox, oy, w, h);
    if (!VEC[v].d) begin
      for (int j = 0; j < nw; j++) begin
        if (j % 2 == 1) @(negedge clk);
        send_word({pix(v, 2 * j + 1), pix(v, 2 * j)});
      end
      wait_done(seen);
      chk(seen, "R9 done pulse", 32'(seen), 1);
      chk(!busy, "R9 busy low", 32'(busy), 0);
      for (int a = 0; a < FBN; a++) ex[a] = 16'hDEAD;
      for (int k = 0; k < np; k++) ex[ref_addr(ox, oy, w, k)] = pix(v, k);
      miss = 0;
      first = -1;
      for (int a = 0; a < FBN; a++)
        if (mem[a] !== ex[a]) begin
          miss++;
          if (first < 0) first = a;
        end
      if (first < 0) first = 0;
      chk(miss == 0, tag, {16'(first), mem[first]}, {16'(first), ex[first]});
    end else begin
      for (int j = 0; j < nw; j++) begin
        n = 0;
        while (!rd_valid && n < 50) begin
          @(negedge clk);
          n++;
        end
        if (j % 4 == 1) begin
          hold = rd_data;
          @(negedge clk);
          @(negedge clk);
          chk(rd_valid && rd_data == hold, "R8 hold", rd_data, hold);
        end
        chk(rd_data == {rpat(ref_addr(ox, oy, w, 2 * j + 1)), rpat(ref_addr(ox, oy, w, 2 * j))},
            tag, rd_data, {rpat(ref_addr(ox, oy, w, 2 * j + 1)), rpat(ref_addr(ox, oy, w, 2 * j))});
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
      end
      wait_done(seen);
      chk(seen, "R9 done pulse", 32'(seen), 1);
      chk(!busy, "R9 busy low", 32'(busy), 0);
    end
  endtask

  initial begin
    bit seen;
    int n;
    int miss;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    chk(!wr_ready && !rd_valid, "R1 handshakes", {wr_ready, rd_valid}, 0);
    chk(!fb_we && !fb_re, "R1 strobes", {fb_we, fb_re}, 0);

    // main table walk
    for (int v = 0; v < 8; v++) run_vec(v);

    // zero-sized starts are ignored
    issue(1'b0, 1, 1, 0, 2);
    chk(!busy, "R2 zero width", 32'(busy), 0);
    issue(1'b1, 1, 1, 3, 0);
    chk(!busy, "R2 zero height", 32'(busy), 0);

    // start while busy ignored, then abort a write midway
    preload(1'b0);
    issue(1'b0, 0, 0, 4, 2);
    chk(busy, "R2 taken", 32'(busy), 1);
    start = 1'b1; dir = 1'b1; org_x = 4'd5; width = 5'd2;
    @(negedge clk);
    start = 1'b0;
    chk(wr_ready && !rd_valid && !fb_re, "R11 direction kept", {wr_ready, rd_valid, fb_re}, 3'b100);
    send_word(32'hBBBB_AAAA);
    @(negedge clk);
    abort = 1'b1;
    wr_data = 32'h1234_5678;
    wr_valid = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(!busy && !done && !wr_ready, "R10 write abort", {busy, done, wr_ready}, 0);
    repeat (3) @(negedge clk);
    wr_valid = 1'b0;
    miss = 0;
    for (int a = 2; a < FBN; a++) if (mem[a] !== 16'hDEAD) miss++;
    chk(mem[0] == 16'hAAAA && mem[1] == 16'hBBBB && miss == 0, "R10 no writes after abort",
        {mem[0], mem[1]}, 32'hAAAA_BBBB);
    chk(!done, "R10 no done", 32'(done), 0);

    // abort a read
    preload(1'b1);
    issue(1'b1, 0, 0, 4, 2);
    n = 0;
    while (!rd_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(rd_valid, "R7 first word offered", 32'(rd_valid), 1);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(!busy && !rd_valid && !done, "R10 read abort", {busy, rd_valid, done}, 0);

    // block is usable again after an abort
    run_vec(4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule